// File: doc/BRIEF.md
# Connector Identification ROM Responder

This block is a standard-mode I2C target. It lets a host controller find out that a video connector is fed through a protocol adaptor. It holds a fixed, read-only identification memory of seventeen bytes. A host addresses the block, can optionally write a one-byte offset, and then reads bytes back. An internal pointer moves forward by one on every acknowledged byte and stops on the last location.

The bus lines are sampled by a faster system clock through two-flop synchronizers. START and STOP are found from the synchronized values. The block pulls SDA low only through an open-drain enable output, and it never stretches the clock. A level-sensitive enable input takes the block off the bus completely.

Top module: `idrom_i2c_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x40, which is address byte 0x80 for a write and 0x81 for a read. For any other address it leaves SDA undriven during the acknowledge bit.
- R2: The memory holds the ASCII characters "DP-HDMI ADAPTOR" at offsets 0x00 to 0x0E, the value 0x04 at offset 0x0F and 0xFF at offset 0x10. Data is sent most significant bit first.
- R3: In a write transaction, the first byte after the address is acknowledged and loads the read pointer. Reads that follow, after a repeated START or after a STOP and a new START, begin at that offset.
- R4: During a read, an acknowledge from the host moves the pointer forward and the next byte is sent. A not-acknowledge makes the block release SDA and stay off the bus until the next STOP or START.
- R5: The pointer saturates at offset 0x10. Every further acknowledged byte returns 0xFF, and the pointer never wraps to 0x00.
- R6: An offset byte above 0x10 is still acknowledged, but it is clamped to 0x10, so the read returns 0xFF.
- R7: While the enable input is low, the block acknowledges nothing and never asserts the SDA output enable.
- R8: A read with no offset write before it returns data starting at offset 0x00, both after reset and after a STOP that ends a read transaction.
- R9: The SDA output enable is never asserted while SCL is high. Changes to it are made only while SCL is low, a few system clocks after the falling edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Responder enable; low takes the block off the bus |
| scl_i | input | 1 | SCL line as seen at the pin |
| sda_i | input | 1 | SDA line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The hardest case to reach is the pointer saturating at the end of memory. A single ordinary read never gets there. It needs an acknowledged run of more than seventeen bytes, or an offset write past the end followed by a repeated START. The stimulus covers both routes. One is a read that starts at offset 0x00 with no offset write and runs three bytes past 0x10. The other is a sweep of every offset from 0x00 to 0x14, each followed by a repeated START and a two-byte read. A second case needs care: the release after a not-acknowledge. It is shown by clocking a further byte with the host letting go of SDA and checking that the line reads all ones.

// File: rtl/idrom_i2c_slave.sv
module idrom_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int         LAST     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PW = $clog2(LAST + 1);
  localparam int NCHR = 15;
  localparam logic [8*NCHR-1:0] ID_TEXT = "DP-HDMI ADAPTOR";
  localparam logic [PW-1:0] LASTP = PW'(LAST);
  localparam logic [7:0] LAST8 = 8'(LAST);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_OFFS, S_OACK, S_TX, S_TACK, S_WAIT} st_t;

  logic [1:0] scl_s, sda_s;
  logic scl_d, sda_d;
  st_t st_q;
  logic [3:0] cnt_q;
  logic [7:0] sr_q;
  logic [PW-1:0] ptr_q;
  logic rw_q, rd_q, mack_q, oe_q;

  wire scl = scl_s[1];
  wire sda = sda_s[1];
  wire start_det = scl & scl_d & sda_d & ~sda;
  wire stop_det = scl & scl_d & ~sda_d & sda;
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;

  function automatic logic [7:0] rom_at(input logic [PW-1:0] p);
    if (int'(p) < NCHR) return ID_TEXT[8*(NCHR-1-int'(p)) +: 8];
    else if (int'(p) == NCHR) return 8'h04;
    else return 8'hFF;
  endfunction

  wire [PW-1:0] ptr_nx = (ptr_q == LASTP) ? ptr_q : ptr_q + 1'b1;
  wire [PW-1:0] offs_clamp = (sr_q > LAST8) ? LASTP : sr_q[PW-1:0];
  wire [7:0] byte_cur = rom_at(ptr_q);
  wire [7:0] byte_nx = rom_at(ptr_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sr_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!en) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
    end else if (start_det) begin
      st_q  <= S_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
      rd_q <= 1'b0;
      if (rd_q) ptr_q <= '0;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (scl_rise) begin
            sr_q  <= {sr_q[6:0], sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sr_q[7:1] == DEV_ADDR) begin
              oe_q <= 1'b1;
              rw_q <= sr_q[0];
              st_q <= S_AACK;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            oe_q <= ~byte_cur[7];
            sr_q <= {byte_cur[6:0], 1'b0};
            rd_q <= 1'b1;
            st_q <= S_TX;
          end else begin
            oe_q <= 1'b0;
            st_q <= S_OFFS;
          end
        end
        S_OFFS: begin
          if (scl_rise) begin
            sr_q  <= {sr_q[6:0], sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            ptr_q <= offs_clamp;
            oe_q  <= 1'b1;
            st_q  <= S_OACK;
          end
        end
        S_OACK: if (scl_fall) begin
          oe_q <= 1'b0;
          st_q <= S_WAIT;
        end
        S_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_q <= 1'b0;
              st_q <= S_TACK;
            end else begin
              oe_q <= ~sr_q[7];
              sr_q <= {sr_q[6:0], 1'b0};
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            mack_q <= ~sda;
          end else if (scl_fall) begin
            if (mack_q) begin
              ptr_q <= ptr_nx;
              oe_q  <= ~byte_nx[7];
              sr_q  <= {byte_nx[6:0], 1'b0};
              cnt_q <= '0;
              st_q  <= S_TX;
            end else begin
              st_q <= S_WAIT;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe = oe_q & en;

  p_ack_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_AACK) |-> oe_q);
  p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == S_TACK && scl_fall && !mack_q && !start_det && !stop_det) |=> !oe_q);
  p_ptr_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= LAST);
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oe_q);
  p_no_drive_on_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl |-> !$rose(oe_q));
endmodule

// File: tb/idrom_i2c_slave_test.sv
module idrom_i2c_slave_test;
  localparam int CLK_NS = 10;
  localparam int QT = 8;
  localparam string IDS = "DP-HDMI ADAPTOR";

  logic clk = 0, rst_n = 0, en = 1, scl_m = 1, sda_m = 1;
  wire sda_oe;
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_fail = 0, oe_cnt = 0, viol = 0;
  logic prev_oe = 0;
  bit done = 0;

  idrom_i2c_slave uut (.clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_m),
                       .sda_i(sda_line), .sda_oe(sda_oe));

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (sda_oe != prev_oe && scl_m) viol <= viol + 1;
  end

  function automatic logic [7:0] exp_at(input int o);
    int p = (o > 16) ? 16 : o;
    if (p < 15) return 8'(IDS[p]);
    else if (p == 15) return 8'h04;
    else return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (QT) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0;
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_line; wq(); scl_m = 0;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0;
    end
    sda_m = ~ack; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); sda_m = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    check(sda_oe == 0, "R9 reset oe", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R8, R2, R5: read with no offset write, run past the end
    i2c_start(); wr_byte(8'h81, ack);
    check(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < 20; i++) begin
      rd_byte(i < 19, b);
      check(b == exp_at(i), $sformatf("R2/R5/R8 byte %0d", i), b, exp_at(i));
    end
    i2c_stop();

    // R3, R6: every offset, then a repeated start read
    for (int o = 0; o <= 20; o++) begin
      i2c_start(); wr_byte(8'h80, ack);
      check(ack, "R1 write address ack", ack, 1);
      wr_byte(8'(o), ack);
      check(ack, $sformatf("R3/R6 offset %0d ack", o), ack, 1);
      i2c_start(); wr_byte(8'h81, ack);
      rd_byte(1, b);
      check(b == exp_at(o), $sformatf("R3/R6 offset %0d first", o), b, exp_at(o));
      rd_byte(0, b);
      check(b == exp_at((o > 16 ? 16 : o) + 1), $sformatf("R4 offset %0d second", o), b,
            exp_at((o > 16 ? 16 : o) + 1));
      i2c_stop();
    end

    // R8: pointer back at 0 after STOP ending a read
    i2c_start(); wr_byte(8'h81, ack); rd_byte(0, b); i2c_stop();
    check(b == exp_at(0), "R8 restart at zero", b, exp_at(0));

    // R3: offset kept across STOP when no read occurred
    i2c_start(); wr_byte(8'h80, ack); wr_byte(8'h05, ack); i2c_stop();
    i2c_start(); wr_byte(8'h81, ack); rd_byte(0, b); i2c_stop();
    check(b == exp_at(5), "R3 offset kept over stop", b, exp_at(5));

    // R4: after NACK the line is released
    i2c_start(); wr_byte(8'h81, ack); rd_byte(0, b);
    check(b == exp_at(0), "R4 byte before nack", b, exp_at(0));
    rd_byte(0, b);
    check(b == 8'hFF, "R4 released after nack", b, 8'hFF);
    i2c_stop();

    // R1: all other addresses ignored
    begin
      int acks = 0;
      for (int a = 0; a < 128; a++) begin
        if (a == 8'h40) continue;
        i2c_start(); wr_byte({7'(a), 1'(a)}, ack); i2c_stop();
        if (ack) acks++;
      end
      check(acks == 0, "R1 foreign addresses acked", acks, 0);
    end

    // R7: disabled
    en = 0; @(negedge clk); oe_cnt = 0;
    i2c_start(); wr_byte(8'h81, ack);
    check(!ack, "R7 no ack when disabled", ack, 0);
    rd_byte(0, b); i2c_stop();
    check(b == 8'hFF, "R7 no data when disabled", b, 8'hFF);
    check(oe_cnt == 0, "R7 oe cycles when disabled", oe_cnt, 0);
    en = 1; repeat (4) @(negedge clk);
    i2c_start(); wr_byte(8'h81, ack); rd_byte(0, b); i2c_stop();
    check(ack && b == exp_at(0), "R7 works when re-enabled", b, exp_at(0));

    check(viol == 0, "R9 oe change while SCL high", viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule